// File: doc/BRIEF.md
# Serial Frequency-Table Programming Port

This block loads entries of an on-chip frequency table, and reads them back, over a bit-serial link built from two of the frequency-select pins. One pin carries the serial clock: each of its 0-to-1 transitions shifts in one bit. A second pin carries the data. The two lowest select pins take no part in programming and do not connect to this block. No chip select exists. Instead, a programmable idle interval with no serial clock edges ends any pending activity and clears the shifter. A frame may follow the previous one directly, with no idle gap between them.

A frame holds 20 bits, each field sent least significant bit first. A write frame stores its payload (feedback value, bypass flag and post-divider code) in the addressed table entry. A read frame fetches the entry into an output shifter. The next eleven serial clock edges then present its bits one at a time on the readback pin. The table lives in a neighbouring block, which this block reaches through a write strobe and a read strobe that share one address. While `busy_o` is high, the surrounding logic must not treat the select pins as a frequency selection.

Top module: `ftab_serial_prog`

## Requirements
- R1: After reset, `busy_o`, `sdo_o`, `tbl_we_o` and `tbl_re_o` are all 0.
- R2: A bit is taken from `sdat_i` only on a 0-to-1 transition of `sclk_i`, after both pins pass through a two-flop synchronizer. A change on `sdat_i` while `sclk_i` is steady has no effect.
- R3: Frame bit k (k = 0 first) maps as follows: 0 = start, 1 = read flag, 2..6 = location (bit 2 = LSB), 7..14 = feedback N (bit 7 = LSB), 15 = bypass, 16..17 = post-divider (bit 16 = LSB), 18..19 = stop bits. A valid frame with read flag 0 pulses `tbl_we_o` for exactly one cycle. On that pulse, `tbl_addr_o` holds the location and `tbl_wdata_o` holds {post-divider[1:0], bypass, N[7:0]}, with N in bits 7:0.
- R4: A valid frame with read flag 1 pulses `tbl_re_o` for one cycle and does not pulse `tbl_we_o`. The table must return the addressed entry on `tbl_rdata_i` in that same cycle.
- R5: After a read frame, each of the next 11 serial clock rising edges drives the next stored bit onto `sdo_o`, in the order N0..N7, bypass, D0, D1. `sdo_o` holds each bit until the next edge.
- R6: A second frame may start on the edge right after the last stop bit of the previous frame, with no idle gap, and is decoded correctly.
- R7: Locations 0..15 address clock-A entries 0..15. Locations 16..19 address clock-B entries 0..3. Locations 20..31 are unused, and a frame that names one is discarded.
- R8: A frame with start bit 1, or with either stop bit 0, is discarded without any table access.
- R9: `busy_o` rises on the first serial clock edge and falls `IDLE_CYCLES` cycles after the last edge. When it falls, any partial frame is dropped, so the next edge is taken as a start bit.
- R10: When `busy_o` falls, a readback still in progress is abandoned and `sdo_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock select pin (asynchronous) |
| sdat_i | input | 1 | Serial data select pin (asynchronous) |
| busy_o | output | 1 | Programming activity; select pins are not a valid frequency choice |
| sdo_o | output | 1 | Readback serial data |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_re_o | output | 1 | Table read strobe |
| tbl_addr_o | output | 5 | Table entry index (= location code) |
| tbl_wdata_o | output | 11 | Entry to write: {post-div, bypass, N} |
| tbl_rdata_i | input | 11 | Entry returned during `tbl_re_o` |

## Verification
The bound checker watches for table strobe problems on every cycle. Neither strobe may last more than a pulse, the two must never overlap, and no strobe may name a location above 19 or occur while `busy_o` is low. It also checks that the readback pin is clear at the moment `busy_o` falls. Only the directed scenarios can show the rest. These cover correct field extraction and bit order, discard of malformed frames, and the exact sequence of readback bits. They also cover the idle interval: it must drop a partial frame, and back-to-back frames must still be framed correctly.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int FRAME_BITS  = 20;
  localparam int LOC_W       = 5;
  localparam int FB_W        = 8;
  localparam int PD_W        = 2;
  localparam int ENTRY_W     = FB_W + 1 + PD_W;
  localparam int NUM_A       = 16;
  localparam int NUM_B       = 4;
  localparam int NUM_ENTRIES = NUM_A + NUM_B;
  localparam int RB_CNT_W    = $clog2(ENTRY_W + 1);
  localparam int BIT_CNT_W   = $clog2(FRAME_BITS);

  typedef struct packed {
    logic [PD_W-1:0] post_div;
    logic            bypass;
    logic [FB_W-1:0] fb;
  } entry_t;
endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fsel_idle_timer.sv
module fsel_idle_timer #(
  parameter int IDLE_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int TW = $clog2(IDLE_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(IDLE_CYCLES);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               left_q <= '0;
    else if (kick_i)           left_q <= LOAD;
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign busy_o   = (left_q != '0);
  assign expire_o = !kick_i && (left_q == TW'(1));
endmodule

// File: rtl/fsel_frame_shift.sv
module fsel_frame_shift
  import fsel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rise_i,
  input  logic               din_i,
  input  logic               clr_i,
  input  logic [ENTRY_W-1:0] tbl_rdata_i,
  output logic               tbl_we_o,
  output logic               tbl_re_o,
  output logic [LOC_W-1:0]   tbl_addr_o,
  output logic [ENTRY_W-1:0] tbl_wdata_o,
  output logic               sdo_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);
  localparam logic [LOC_W-1:0]     LAST_LOC = LOC_W'(NUM_ENTRIES - 1);
  localparam logic [RB_CNT_W-1:0]  RB_LEN   = RB_CNT_W'(ENTRY_W);

  logic [FRAME_BITS-1:0] sr_q, full;
  logic [BIT_CNT_W-1:0]  cnt_q;
  logic [RB_CNT_W-1:0]   rb_left_q;
  logic [ENTRY_W-1:0]    rb_q;
  logic                  sdo_q, we_q, re_q;
  logic [LOC_W-1:0]      addr_q;
  logic [ENTRY_W-1:0]    wdata_q;

  logic                  start_b, rd_b, frame_ok, frame_end;
  logic [LOC_W-1:0]      loc;
  logic [ENTRY_W-1:0]    payload;
  logic [1:0]            stops;

  assign full      = {din_i, sr_q[FRAME_BITS-1:1]};
  assign start_b   = full[0];
  assign rd_b      = full[1];
  assign loc       = full[1+LOC_W:2];
  assign payload   = full[1+LOC_W+ENTRY_W:2+LOC_W];
  assign stops     = full[FRAME_BITS-1:FRAME_BITS-2];
  assign frame_ok  = !start_b && (stops == 2'b11) && (loc <= LAST_LOC);
  assign frame_end = (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      rb_left_q <= '0;
      rb_q      <= '0;
      sdo_q     <= 1'b0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (re_q) rb_q <= tbl_rdata_i;
      if (clr_i) begin
        sr_q      <= '0;
        cnt_q     <= '0;
        rb_left_q <= '0;
        sdo_q     <= 1'b0;
      end else if (rise_i) begin
        if (rb_left_q != '0) begin
          // readback: present next entry bit
          sdo_q     <= rb_q[0];
          rb_q      <= rb_q >> 1;
          rb_left_q <= rb_left_q - 1'b1;
        end else begin
          sr_q <= full;
          if (frame_end) begin
            cnt_q <= '0;
            if (frame_ok) begin
              addr_q <= loc;
              if (rd_b) begin
                re_q      <= 1'b1;
                rb_left_q <= RB_LEN;
              end else begin
                we_q    <= 1'b1;
                wdata_q <= payload;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign tbl_we_o    = we_q;
  assign tbl_re_o    = re_q;
  assign tbl_addr_o  = addr_q;
  assign tbl_wdata_o = wdata_q;
  assign sdo_o       = sdo_q;
endmodule

// File: rtl/ftab_serial_prog.sv
module ftab_serial_prog
  import fsel_pkg::*;
#(
  parameter int IDLE_CYCLES = 5_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdat_i,
  output logic               busy_o,
  output logic               sdo_o,
  output logic               tbl_we_o,
  output logic               tbl_re_o,
  output logic [LOC_W-1:0]   tbl_addr_o,
  output logic [ENTRY_W-1:0] tbl_wdata_o,
  input  logic [ENTRY_W-1:0] tbl_rdata_i
);
  logic [1:0] pins_s;
  logic       sclk_d_q, rise, expire;

  fsel_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdat_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= pins_s[1];
  end

  assign rise = pins_s[1] && !sclk_d_q;

  fsel_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (rise),
    .busy_o  (busy_o),
    .expire_o(expire)
  );

  fsel_frame_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .din_i      (pins_s[0]),
    .clr_i      (expire),
    .tbl_rdata_i(tbl_rdata_i),
    .tbl_we_o   (tbl_we_o),
    .tbl_re_o   (tbl_re_o),
    .tbl_addr_o (tbl_addr_o),
    .tbl_wdata_o(tbl_wdata_o),
    .sdo_o      (sdo_o)
  );
endmodule

// File: rtl/ftab_serial_prog_chk.sv
module ftab_serial_prog_chk
  import fsel_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             sdo_o,
  input logic             tbl_we_o,
  input logic             tbl_re_o,
  input logic [LOC_W-1:0] tbl_addr_o
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_ENTRIES - 1);

  // R3
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |=> !tbl_we_o);

  // R4
  re_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_re_o |=> !tbl_re_o);

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tbl_we_o, tbl_re_o}));

  // R7
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o || tbl_re_o) |-> (tbl_addr_o <= LAST_LOC));

  // R9
  access_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o || tbl_re_o) |-> busy_o);

  // R10
  idle_sdo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !sdo_o);
endmodule

bind ftab_serial_prog ftab_serial_prog_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .sdo_o     (sdo_o),
  .tbl_we_o  (tbl_we_o),
  .tbl_re_o  (tbl_re_o),
  .tbl_addr_o(tbl_addr_o)
);

// File: tb/ftab_serial_prog_tb_top.sv
module ftab_serial_prog_tb_top;
  localparam int IDLE = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdat = 1'b0;
  logic        busy, sdo, we, re;
  logic [4:0]  addr;
  logic [10:0] wdata, rdata;

  logic [10:0] mem [20];
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  ftab_serial_prog #(.IDLE_CYCLES(IDLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat),
    .busy_o(busy), .sdo_o(sdo), .tbl_we_o(we), .tbl_re_o(re),
    .tbl_addr_o(addr), .tbl_wdata_o(wdata), .tbl_rdata_i(rdata)
  );

  assign rdata = (addr < 5'd20) ? mem[addr] : 11'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 20; i++) mem[i] <= 11'(i * 37 + 5);
    end else begin
      if (we) begin
        if (addr < 5'd20) mem[addr] <= wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (re) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic noisy);
    sdat = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    if (noisy) sdat = ~b;
    wait_clk(4);
    sclk = 1'b0;
    if (noisy) begin
      wait_clk(2);
      sdat = b;
    end
    wait_clk(2);
  endtask

  task automatic send_frame(input logic st, input logic rw, input logic [4:0] loc,
                            input logic [10:0] pay, input logic [1:0] stp, input logic noisy);
    logic [19:0] f;
    f = {stp, pay, loc, rw, st};
    for (int i = 0; i < 20; i++) send_bit(f[i], noisy);
  endtask

  task automatic go_idle;
    wait_clk(IDLE + 10);
  endtask

  task automatic t_reset;
    wait_clk(2);
    check("R1 busy", 32'(busy), 0);
    check("R1 sdo", 32'(sdo), 0);
    check("R1 strobes", 32'({we, re}), 0);
  endtask

  task automatic t_write_a;
    int w0;
    w0 = wr_cnt;
    send_frame(1'b0, 1'b0, 5'd3, 11'h5A3, 2'b11, 1'b0);
    wait_clk(4);
    check("R3 write count", 32'(wr_cnt - w0), 1);
    check("R3 entry 3", 32'(mem[3]), 32'h5A3);
    check("R4 no read on write", 32'(rd_cnt), 0);
    go_idle();
  endtask

  task automatic t_noise;
    send_frame(1'b0, 1'b0, 5'd7, 11'h2C9, 2'b11, 1'b1);
    wait_clk(4);
    check("R2 entry 7 under data noise", 32'(mem[7]), 32'h2C9);
    go_idle();
  endtask

  task automatic t_write_b;
    send_frame(1'b0, 1'b0, 5'd18, 11'h4F1, 2'b11, 1'b0);
    wait_clk(4);
    check("R7 clock-B entry 2", 32'(mem[18]), 32'h4F1);
    go_idle();
  endtask

  task automatic t_back2back;
    int w0;
    w0 = wr_cnt;
    send_frame(1'b0, 1'b0, 5'd0, 11'h123, 2'b11, 1'b0);
    send_frame(1'b0, 1'b0, 5'd19, 11'h7FE, 2'b11, 1'b0);
    wait_clk(4);
    check("R6 two writes", 32'(wr_cnt - w0), 2);
    check("R6 entry 0", 32'(mem[0]), 32'h123);
    check("R6 entry 19", 32'(mem[19]), 32'h7FE);
    go_idle();
  endtask

  task automatic t_bad;
    int w0, r0;
    logic [10:0] m5;
    w0 = wr_cnt; r0 = rd_cnt; m5 = mem[5];
    send_frame(1'b1, 1'b0, 5'd5, 11'h0AA, 2'b11, 1'b0);
    go_idle();
    send_frame(1'b0, 1'b0, 5'd5, 11'h0AA, 2'b01, 1'b0);
    go_idle();
    send_frame(1'b0, 1'b0, 5'd5, 11'h0AA, 2'b10, 1'b0);
    go_idle();
    check("R8 bad framing no access", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
    check("R8 entry 5 kept", 32'(mem[5]), 32'(m5));
    send_frame(1'b0, 1'b0, 5'd20, 11'h0AA, 2'b11, 1'b0);
    send_frame(1'b0, 1'b1, 5'd31, 11'h0AA, 2'b11, 1'b0);
    wait_clk(4);
    check("R7 unused codes no access", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
    go_idle();
  endtask

  task automatic t_read;
    int w0, r0;
    logic [10:0] e;
    w0 = wr_cnt; r0 = rd_cnt; e = mem[3];
    send_frame(1'b0, 1'b1, 5'd3, 11'h000, 2'b11, 1'b0);
    wait_clk(4);
    check("R4 one read", 32'(rd_cnt - r0), 1);
    check("R4 no write", 32'(wr_cnt - w0), 0);
    check("R4 entry unchanged", 32'(mem[3]), 32'(e));
    for (int i = 0; i < 11; i++) begin
      sclk = 1'b1;
      wait_clk(5);
      check($sformatf("R5 readback bit %0d", i), 32'(sdo), 32'(e[i]));
      sclk = 1'b0;
      wait_clk(5);
    end
    go_idle();
  endtask

  task automatic t_timeout;
    int w0;
    w0 = wr_cnt;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    check("R9 busy during partial frame", 32'(busy), 1);
    go_idle();
    check("R9 busy after idle", 32'(busy), 0);
    send_frame(1'b0, 1'b0, 5'd9, 11'h3C5, 2'b11, 1'b0);
    wait_clk(4);
    check("R9 fresh frame write count", 32'(wr_cnt - w0), 1);
    check("R9 entry 9", 32'(mem[9]), 32'h3C5);
    go_idle();
  endtask

  task automatic t_rb_abort;
    send_frame(1'b0, 1'b0, 5'd12, 11'h5FF, 2'b11, 1'b0);
    send_frame(1'b0, 1'b1, 5'd12, 11'h000, 2'b11, 1'b0);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; wait_clk(5); sclk = 1'b0; wait_clk(5);
    end
    check("R5 third bit before abort", 32'(sdo), 1);
    go_idle();
    check("R10 sdo cleared on idle", 32'(sdo), 0);
    send_frame(1'b0, 1'b0, 5'd13, 11'h011, 2'b11, 1'b0);
    wait_clk(4);
    check("R10 framing after abort", 32'(mem[13]), 32'h011);
    go_idle();
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    t_reset();
    t_write_a();
    t_noise();
    t_write_b();
    t_back2back();
    t_bad();
    t_read();
    t_timeout();
    t_rb_abort();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule